// File: doc/BRIEF.md
# Vector Length Setup Unit

This unit carries out the 12-bit length-control field of a 64-bit prefixed instruction. It holds a small local state word that records the maximum vector length, the current vector length and the element offsets that the element loop uses. It also provides plain read and write access to that word. When an instruction with a nonzero field is presented, the unit picks one of four length modes from bits 11 and 0 of the field:

- a loop mode with an immediate length;
- a loop mode that takes the length from a scalar register;
- a one-off mode that sets both limits;
- a one-off mode that sets the maximum and trims the current length to fit.

Where the field names a scalar destination, the resulting length is written back to it. A field of all zeros leaves the local state alone, so the instruction runs on the global vector state.

Register-sourced lengths arrive through a combinational read port: the unit drives the register index, and the surrounding pipeline returns the value in the same cycle. The state update, the writeback strobe and the illegal-instruction flag all appear one clock after the request. Illegal requests never modify the state.

Top module: `vlen_setup_unit`

## Requirements
- R1: After reset the state word is all zeros, and both the writeback strobe and the illegal flag are low.
- R2: An instruction whose 12-bit field is zero changes no state, raises no writeback and raises no illegal flag. With no request at all, the state holds.
- R3: With field bit 11 = 0 and bit 0 = 0 (immediate loop mode), the new VL is min(bits[5:1] + 1, MAXVL). MAXVL does not change, and VL never exceeds MAXVL.
- R4: With bit 11 = 0 and bit 0 = 1 (register loop mode), the read index output carries bits[5:1], and the new VL is min(register value, MAXVL), compared over the full register width. An index of zero is illegal.
- R5: With bit 11 = 1 and bit 0 = 0, both MAXVL and VL become bits[5:1] + 1.
- R6: With bit 11 = 1 and bit 0 = 1, MAXVL becomes bits[5:1] + 1, and VL becomes min(old VL, new MAXVL).
- R7: Field bits[10:6] name the writeback register. One cycle after a legal nonzero field, the writeback strobe is high for one cycle, carrying that index and the new VL zero-extended. No writeback happens for index zero.
- R8: If VL or MAXVL changes, srcoffs, destoffs and dsvoffs are cleared. If neither changes, they are kept. subvl is always kept.
- R9: When length override is disabled by configuration, any nonzero field is illegal.
- R10: An illegal request raises the illegal flag for one cycle, one cycle after the request. It leaves the state unchanged and produces no writeback.
- R11: A state write is applied one cycle later. It is rejected as illegal, leaving the state unchanged, when any of these holds: a reserved bit [31:28] is set; the written vl is greater than the written maxvl; or override is disabled and any of bits [23:0] is set.
- R12: When an instruction and a state write arrive in the same cycle, the instruction is applied and the write is dropped.
- R13: State word layout: maxvl [5:0], vl [11:6], srcoffs [17:12], destoffs [23:18], subvl [25:24], dsvoffs [27:26], reserved [31:28]. The vl field holds the length value itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len_en | input | 1 | Length override supported |
| ins_valid | input | 1 | Instruction field valid strobe |
| ins_ctrl | input | 12 | Length-control field |
| rs_idx | output | 5 | Scalar register read index |
| rs_data | input | XLEN | Scalar register read data (same cycle) |
| csr_we | input | 1 | State word write strobe |
| csr_wdata | input | 32 | State word write data |
| state_q | output | 32 | Current state word (read port) |
| wb_valid | output | 1 | Scalar writeback strobe |
| wb_idx | output | 5 | Scalar writeback register index |
| wb_data | output | XLEN | Scalar writeback value |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The bench builds the unit with its default parameters: XLEN = 64 and a 6-bit length field, which gives the 32-bit state word. The 64-bit register port allows register values whose low bits are small but whose upper word is nonzero. This shows that the clamp against MAXVL compares the full register width and not a truncated copy. The 6-bit length fields allow the one-off immediates to reach 16 and more, so truncation is checked both when it trims VL and when it leaves VL alone.

// File: rtl/vls_pkg.sv
// Package: shared mode encoding for the vector length setup unit.
// Assumes the 12-bit control field with bit 11 selecting loop / one-off
// behaviour and bit 0 selecting the sub-variant.
package vls_pkg;

    localparam int CTRL_W = 12;
    localparam int IDX_W  = 5;

    typedef enum logic [2:0] {
        VM_NONE      = 3'd0,
        VM_LOOP_IMM  = 3'd1,
        VM_LOOP_REG  = 3'd2,
        VM_ONE_SET   = 3'd3,
        VM_ONE_TRUNC = 3'd4
    } vl_mode_e;

endpackage

// File: rtl/vls_decode.sv
// Module: vls_decode
// Splits the length-control field into mode, immediate, source and
// destination register indices, and classifies the request as acting,
// illegal or neutral. Purely combinational.
// Assumes: field is meaningful only while ins_valid is high.
module vls_decode
    import vls_pkg::*;
(
    input  logic                ins_valid,
    input  logic [CTRL_W-1:0]   ins_ctrl,
    input  logic                cfg_len_en,
    output vl_mode_e            mode,
    output logic [IDX_W-1:0]    imm,
    output logic [IDX_W-1:0]    src_idx,
    output logic [IDX_W-1:0]    dst_idx,
    output logic                act,
    output logic                bad
);

    logic nonzero;

    // Field slicing
    assign imm     = ins_ctrl[5:1];
    assign src_idx = ins_ctrl[5:1];
    assign dst_idx = ins_ctrl[10:6];
    assign nonzero = |ins_ctrl;

    // Mode selection from bits 11 and 0
    always_comb begin
        if (!nonzero)
            mode = VM_NONE;
        else if (!ins_ctrl[11])
            mode = ins_ctrl[0] ? VM_LOOP_REG : VM_LOOP_IMM;
        else
            mode = ins_ctrl[0] ? VM_ONE_TRUNC : VM_ONE_SET;
    end

    // Legality: disabled override or register mode naming x0
    always_comb begin
        bad = 1'b0;
        if (ins_valid && nonzero) begin
            if (!cfg_len_en)
                bad = 1'b1;
            else if (mode == VM_LOOP_REG && src_idx == '0)
                bad = 1'b1;
        end
    end

    assign act = ins_valid && nonzero && !bad;

endmodule

// File: rtl/vls_len_calc.sv
// Module: vls_len_calc
// Computes the next MAXVL and VL for a decoded mode from the current
// values, the immediate and the scalar register value. Combinational.
// Assumes: LEN_W >= IDX_W + 1 so that immediate + 1 always fits,
// and XLEN >= LEN_W.
module vls_len_calc
    import vls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 6
) (
    input  vl_mode_e            mode,
    input  logic [IDX_W-1:0]    imm,
    input  logic [XLEN-1:0]     rs_data,
    input  logic [LEN_W-1:0]    cur_max,
    input  logic [LEN_W-1:0]    cur_vl,
    output logic [LEN_W-1:0]    new_max,
    output logic [LEN_W-1:0]    new_vl,
    output logic                changed
);

    localparam int PAD_W = XLEN - LEN_W;

    logic [LEN_W-1:0] imm_p1;
    logic [LEN_W-1:0] imm_clamped;
    logic [LEN_W-1:0] reg_clamped;
    logic [LEN_W-1:0] trunc_vl;
    logic [XLEN-1:0]  max_wide;

    // Immediate plus one, widened to the length field
    assign imm_p1 = LEN_W'(imm) + LEN_W'(1);

    // Full-width comparison of register value against MAXVL
    assign max_wide    = {{PAD_W{1'b0}}, cur_max};
    assign reg_clamped = (rs_data > max_wide) ? cur_max : rs_data[LEN_W-1:0];

    // Immediate loop length limited by the current MAXVL
    assign imm_clamped = (imm_p1 > cur_max) ? cur_max : imm_p1;

    // Current VL trimmed to the new maximum
    assign trunc_vl = (cur_vl > imm_p1) ? imm_p1 : cur_vl;

    // Mode multiplexer for the next limits
    always_comb begin
        new_max = cur_max;
        new_vl  = cur_vl;
        unique case (mode)
            VM_LOOP_IMM:  new_vl = imm_clamped;
            VM_LOOP_REG:  new_vl = reg_clamped;
            VM_ONE_SET: begin
                new_max = imm_p1;
                new_vl  = imm_p1;
            end
            VM_ONE_TRUNC: begin
                new_max = imm_p1;
                new_vl  = trunc_vl;
            end
            default: ;
        endcase
    end

    assign changed = (new_max != cur_max) || (new_vl != cur_vl);

endmodule

// File: rtl/vls_state_reg.sv
// Module: vls_state_reg
// Holds the local length state word, applies instruction updates or
// state writes, and registers the writeback and illegal outputs.
// Assumes: an instruction present in a cycle takes priority over a
// state write; illegal requests never modify the state.
module vls_state_reg
    import vls_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_len_en,
    input  logic                    ins_valid,
    input  logic                    ins_act,
    input  logic                    ins_bad,
    input  logic                    len_changed,
    input  logic [LEN_W-1:0]        new_max,
    input  logic [LEN_W-1:0]        new_vl,
    input  logic [IDX_W-1:0]        dst_idx,
    input  logic                    csr_we,
    input  logic [4*LEN_W+7:0]      csr_wdata,
    output logic [4*LEN_W+7:0]      state_q,
    output logic [LEN_W-1:0]        cur_max,
    output logic [LEN_W-1:0]        cur_vl,
    output logic                    wb_valid,
    output logic [IDX_W-1:0]        wb_idx,
    output logic [LEN_W-1:0]        wb_len,
    output logic                    illegal
);

    localparam int ST_W    = 4*LEN_W + 8;
    localparam int O_MAX   = 0;
    localparam int O_VL    = LEN_W;
    localparam int O_SRC   = 2*LEN_W;
    localparam int O_DST   = 3*LEN_W;
    localparam int O_SUB   = 4*LEN_W;
    localparam int O_DSV   = 4*LEN_W + 2;
    localparam int O_RSV   = 4*LEN_W + 4;

    logic [ST_W-1:0]  st_d;
    logic             wbv_d;
    logic             ill_d;
    logic             csr_bad;
    logic [LEN_W-1:0] w_max;
    logic [LEN_W-1:0] w_vl;

    assign cur_max = state_q[O_MAX +: LEN_W];
    assign cur_vl  = state_q[O_VL  +: LEN_W];
    assign w_max   = csr_wdata[O_MAX +: LEN_W];
    assign w_vl    = csr_wdata[O_VL  +: LEN_W];

    // Legality of a state write: reserved bits, VL bound, unsupported fields
    always_comb begin
        csr_bad = 1'b0;
        if (|csr_wdata[O_RSV +: 4])
            csr_bad = 1'b1;
        else if (w_vl > w_max)
            csr_bad = 1'b1;
        else if (!cfg_len_en && (|csr_wdata[O_SUB-1:0]))
            csr_bad = 1'b1;
    end

    // Next-state selection with instruction priority
    always_comb begin
        st_d  = state_q;
        wbv_d = 1'b0;
        ill_d = 1'b0;
        if (ins_valid) begin
            if (ins_bad) begin
                ill_d = 1'b1;
            end else if (ins_act) begin
                st_d[O_MAX +: LEN_W] = new_max;
                st_d[O_VL  +: LEN_W] = new_vl;
                if (len_changed) begin
                    st_d[O_SRC +: LEN_W] = '0;
                    st_d[O_DST +: LEN_W] = '0;
                    st_d[O_DSV +: 2]     = '0;
                end
                wbv_d = (dst_idx != '0);
            end
        end else if (csr_we) begin
            if (csr_bad)
                ill_d = 1'b1;
            else
                st_d = csr_wdata;
        end
    end

    // State word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= st_d;
    end

    // Writeback and illegal output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_len   <= '0;
            illegal  <= 1'b0;
        end else begin
            wb_valid <= wbv_d;
            wb_idx   <= dst_idx;
            wb_len   <= new_vl;
            illegal  <= ill_d;
        end
    end

    // R13
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[O_RSV +: 4] == 4'd0);

    // R3
    vl_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_vl <= cur_max);

    // R7
    wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ins_valid));

    // R7
    wb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != '0));

    // R7
    wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_len == cur_vl));

    // R10
    ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wb_valid);

    // R10
    ill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(state_q));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !csr_we) |=> $stable(state_q));

endmodule

// File: rtl/vlen_setup_unit.sv
// Module: vlen_setup_unit
// Top level of the vector length setup unit: decodes the length-control
// field, computes new limits and keeps the local state word.
// Assumes: rs_data returns the register named by rs_idx in the same
// cycle; results appear one clock after the request.
module vlen_setup_unit
    import vls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_len_en,
    input  logic                    ins_valid,
    input  logic [11:0]             ins_ctrl,
    output logic [4:0]              rs_idx,
    input  logic [XLEN-1:0]         rs_data,
    input  logic                    csr_we,
    input  logic [4*LEN_W+7:0]      csr_wdata,
    output logic [4*LEN_W+7:0]      state_q,
    output logic                    wb_valid,
    output logic [4:0]              wb_idx,
    output logic [XLEN-1:0]         wb_data,
    output logic                    illegal
);

    localparam int PAD_W = XLEN - LEN_W;

    vl_mode_e          mode;
    logic [IDX_W-1:0]  imm;
    logic [IDX_W-1:0]  dst_idx;
    logic              act;
    logic              bad;
    logic [LEN_W-1:0]  cur_max;
    logic [LEN_W-1:0]  cur_vl;
    logic [LEN_W-1:0]  new_max;
    logic [LEN_W-1:0]  new_vl;
    logic              changed;
    logic [LEN_W-1:0]  wb_len;

    vls_decode u_dec (
        .ins_valid  (ins_valid),
        .ins_ctrl   (ins_ctrl),
        .cfg_len_en (cfg_len_en),
        .mode       (mode),
        .imm        (imm),
        .src_idx    (rs_idx),
        .dst_idx    (dst_idx),
        .act        (act),
        .bad        (bad)
    );

    vls_len_calc #(.XLEN(XLEN), .LEN_W(LEN_W)) u_calc (
        .mode    (mode),
        .imm     (imm),
        .rs_data (rs_data),
        .cur_max (cur_max),
        .cur_vl  (cur_vl),
        .new_max (new_max),
        .new_vl  (new_vl),
        .changed (changed)
    );

    vls_state_reg #(.LEN_W(LEN_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_len_en  (cfg_len_en),
        .ins_valid   (ins_valid),
        .ins_act     (act),
        .ins_bad     (bad),
        .len_changed (changed),
        .new_max     (new_max),
        .new_vl      (new_vl),
        .dst_idx     (dst_idx),
        .csr_we      (csr_we),
        .csr_wdata   (csr_wdata),
        .state_q     (state_q),
        .cur_max     (cur_max),
        .cur_vl      (cur_vl),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .wb_len      (wb_len),
        .illegal     (illegal)
    );

    // Writeback value zero-extended to register width
    assign wb_data = {{PAD_W{1'b0}}, wb_len};

endmodule

// File: tb/vlen_setup_unit_tb_top.sv
module vlen_setup_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_len_en = 1'b1;
    logic        ins_valid = 1'b0;
    logic [11:0] ins_ctrl = '0;
    logic [4:0]  rs_idx;
    logic [63:0] rs_data = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] state_q;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vlen_setup_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len_en(cfg_len_en),
        .ins_valid(ins_valid), .ins_ctrl(ins_ctrl), .rs_idx(rs_idx),
        .rs_data(rs_data), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .state_q(state_q), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input int mx, input int vl, input int so,
                                       input int dof, input int sv, input int dsv);
        return {4'd0, 2'(dsv), 2'(sv), 6'(dof), 6'(so), 6'(vl), 6'(mx)};
    endfunction

    function automatic logic [11:0] fld(input logic b11, input int dst,
                                        input int imm, input logic b0);
        return {b11, 5'(dst), 5'(imm), b0};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Present one instruction for one cycle; returns at the sample point
    task automatic issue(input logic [11:0] f, input logic [63:0] rd);
        ins_ctrl  = f;
        rs_data   = rd;
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        csr_wdata = d;
        csr_we    = 1'b1;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", state_q, 0);
        chk("R1 wb_valid", wb_valid, 0);
        chk("R1 illegal", illegal, 0);
    endtask

    task automatic t_zero();
        issue(12'd0, 64'd0);
        chk("R2 state", state_q, 0);
        chk("R2 wb", wb_valid, 0);
        chk("R2 ill", illegal, 0);
    endtask

    task automatic t_one_set();
        issue(fld(1, 3, 9, 0), 0);
        chk("R5 state", state_q, mk(10, 10, 0, 0, 0, 0));
        chk("R7 wb_valid", wb_valid, 1);
        chk("R7 wb_idx", wb_idx, 3);
        chk("R7 wb_data", wb_data, 10);
        @(negedge clk);
        chk("R7 wb single cycle", wb_valid, 0);
    endtask

    task automatic t_loop_imm();
        issue(fld(0, 0, 3, 0), 0);
        chk("R3 vl imm", state_q, mk(10, 4, 0, 0, 0, 0));
        chk("R7 no wb x0", wb_valid, 0);
        issue(fld(0, 4, 20, 0), 0);
        chk("R3 clamp", state_q, mk(10, 10, 0, 0, 0, 0));
        chk("R7 wb clamp data", wb_data, 10);
    endtask

    task automatic t_loop_reg();
        ins_ctrl = fld(0, 0, 7, 1);
        #1;
        chk("R4 rs_idx", rs_idx, 7);
        issue(fld(0, 0, 7, 1), 64'd6);
        chk("R4 vl reg", state_q, mk(10, 6, 0, 0, 0, 0));
        issue(fld(0, 2, 7, 1), 64'h1_0000_0002);
        chk("R4 wide clamp", state_q, mk(10, 10, 0, 0, 0, 0));
        issue(fld(0, 0, 7, 1), 64'd6);
        issue(fld(0, 5, 0, 1), 64'd3);
        chk("R4 x0 illegal", illegal, 1);
        chk("R10 state kept", state_q, mk(10, 6, 0, 0, 0, 0));
        chk("R10 no wb", wb_valid, 0);
        @(negedge clk);
        chk("R10 pulse one cycle", illegal, 0);
    endtask

    task automatic t_trunc();
        issue(fld(1, 0, 3, 1), 0);
        chk("R6 trim", state_q, mk(4, 4, 0, 0, 0, 0));
        issue(fld(1, 0, 15, 1), 0);
        chk("R6 keep vl", state_q, mk(16, 4, 0, 0, 0, 0));
    endtask

    task automatic t_offsets();
        wr(mk(8, 4, 3, 5, 2, 1));
        chk("R11 write applied", state_q, mk(8, 4, 3, 5, 2, 1));
        issue(fld(1, 0, 7, 1), 0);
        chk("R8 offsets kept", state_q, mk(8, 4, 3, 5, 2, 1));
        issue(fld(0, 0, 1, 0), 0);
        chk("R8 offsets cleared", state_q, mk(8, 2, 0, 0, 2, 0));
    endtask

    task automatic t_csr_reject();
        wr(mk(8, 2, 0, 0, 2, 0) | 32'h1000_0000);
        chk("R11 reserved ill", illegal, 1);
        chk("R11 reserved kept", state_q, mk(8, 2, 0, 0, 2, 0));
        wr(mk(3, 5, 0, 0, 0, 0));
        chk("R11 vl>max ill", illegal, 1);
        chk("R11 vl>max kept", state_q, mk(8, 2, 0, 0, 2, 0));
    endtask

    task automatic t_disabled();
        cfg_len_en = 1'b0;
        issue(fld(1, 3, 2, 0), 0);
        chk("R9 ill", illegal, 1);
        chk("R9 state", state_q, mk(8, 2, 0, 0, 2, 0));
        chk("R9 no wb", wb_valid, 0);
        issue(12'd0, 0);
        chk("R2 zero while disabled", illegal, 0);
        wr(mk(1, 0, 0, 0, 0, 0));
        chk("R11 unsupported ill", illegal, 1);
        wr(mk(0, 0, 0, 0, 1, 0));
        chk("R11 subvl only", state_q, mk(0, 0, 0, 0, 1, 0));
        chk("R11 subvl no ill", illegal, 0);
        cfg_len_en = 1'b1;
    endtask

    task automatic t_collide();
        csr_wdata = mk(9, 9, 1, 1, 0, 0);
        csr_we    = 1'b1;
        issue(fld(1, 0, 2, 0), 0);
        csr_we    = 1'b0;
        chk("R12 ins wins", state_q, mk(3, 3, 0, 0, 1, 0));
        chk("R13 vl field", {58'd0, state_q[11:6]}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_one_set();
        t_loop_imm();
        t_loop_reg();
        t_trunc();
        t_offsets();
        t_csr_reject();
        t_disabled();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule